// File: doc/BRIEF.md
# Stepper Phase Port with Head Direction Decode

This block is a drive-control output port register. Each write stores a byte, with one reserved bit forced low. The two lowest stored bits are the present phase of a four-phase head stepper motor. The block compares the phase already held with the phase in the incoming byte, modulo four. From that comparison it raises a single-clock pulse that moves the head outward or inward. It raises no pulse when the phase is unchanged or when the new phase is the opposite one.

A separate bit drives the drive activity LED. Its level is always available as an output. Any write that flips this bit also produces a one-clock update strobe. The strobe appears together with the new level, so a display or status consumer can react to the change without polling the port.

Top module: `stepper_port_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, `port_q`, `step_in`, `step_out`, `led_level` and `led_strobe` are all 0.
- R2: On a clock edge with `wr_en` high, `port_q` becomes `wr_data` with bit 4 forced to 0. All other bits are kept as written.
- R3: On a write where the held phase `port_q[1:0]` equals (`wr_data[1:0]` + 1) mod 4, `step_out` is 1 in the following cycle and `step_in` is 0.
- R4: On a write where the held phase `port_q[1:0]` equals (`wr_data[1:0]` - 1) mod 4, `step_in` is 1 in the following cycle and `step_out` is 0.
- R5: On a write whose phase equals the held phase, or differs from it by 2, neither `step_in` nor `step_out` is raised.
- R6: `led_level` always equals bit 3 of the stored port value.
- R7: On a write where `wr_data[3]` differs from the stored bit 3, `led_strobe` is 1 in the following cycle. A write that leaves bit 3 unchanged raises no strobe.
- R8: Step and LED strobes last exactly one clock. Without a write, `port_q` holds its value and all strobes are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the port |
| wr_data | input | 8 | Byte to write |
| port_q | output | 8 | Stored port value, bit 4 always 0 |
| step_in | output | 1 | One-clock pulse: step head inward |
| step_out | output | 1 | One-clock pulse: step head outward |
| led_level | output | 1 | Present LED level (stored bit 3) |
| led_strobe | output | 1 | One-clock pulse when the LED bit changes |

## Verification
The bench builds the block with its defaults: an 8-bit port, the phase at bits 1:0, the LED at bit 3 and the cleared bit at 4. With these values every combination of held phase and LED state can be paired with all 256 written bytes. This covers every phase transition, including the no-step cases for the same phase and the opposite phase, as well as both LED toggle directions and the masking of bit 4. After each write, an idle cycle confirms that the pulses drop again and that the port holds its value.

// File: rtl/stepper_port_pkg.sv
package stepper_port_pkg;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_OUT  = 2'd1,
    DIR_IN   = 2'd2
  } head_dir_e;

  // Old phase one ahead of new: outward. Old phase one behind new: inward.
  function automatic head_dir_e phase_dir(input logic [1:0] held, input logic [1:0] next);
    logic [1:0] next_up;
    logic [1:0] next_dn;
    next_up = next + 2'd1;
    next_dn = next - 2'd1;
    if (held == next_up)      phase_dir = DIR_OUT;
    else if (held == next_dn) phase_dir = DIR_IN;
    else                      phase_dir = DIR_NONE;
  endfunction

endpackage

// File: rtl/stepper_phase_decode.sv
module stepper_phase_decode
  import stepper_port_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  logic [PH_W-1:0] held_ph,
  input  logic [PH_W-1:0] next_ph,
  output logic            hit_out,
  output logic            hit_in
);
  head_dir_e dir;

  generate
    if (PH_W == 2) begin : g_four_phase
      always_comb dir = phase_dir(held_ph, next_ph);
    end else begin : g_wide_phase
      always_comb begin
        if (held_ph == next_ph + PH_W'(1))      dir = DIR_OUT;
        else if (held_ph == next_ph - PH_W'(1)) dir = DIR_IN;
        else                                    dir = DIR_NONE;
      end
    end
  endgenerate

  assign hit_out = (dir == DIR_OUT);
  assign hit_in  = (dir == DIR_IN);
endmodule

// File: rtl/led_toggle_detect.sv
module led_toggle_detect (
  input  logic wr_en,
  input  logic held_bit,
  input  logic next_bit,
  output logic toggled
);
  assign toggled = wr_en & (held_bit ^ next_bit);
endmodule

// File: rtl/stepper_port_ctl.sv
module stepper_port_ctl #(
  parameter int DW       = 8,
  parameter int PH_LSB   = 0,
  parameter int PH_W     = 2,
  parameter int LED_BIT  = 3,
  parameter int ZERO_BIT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] port_q,
  output logic          step_in,
  output logic          step_out,
  output logic          led_level,
  output logic          led_strobe
);
  localparam logic [DW-1:0] KEEP_MASK = ~(DW'(1) << ZERO_BIT);

  logic hit_out, hit_in, led_flip;

  stepper_phase_decode #(.PH_W(PH_W)) u_phase (
    .held_ph (port_q[PH_LSB +: PH_W]),
    .next_ph (wr_data[PH_LSB +: PH_W]),
    .hit_out (hit_out),
    .hit_in  (hit_in)
  );

  led_toggle_detect u_led (
    .wr_en    (wr_en),
    .held_bit (port_q[LED_BIT]),
    .next_bit (wr_data[LED_BIT]),
    .toggled  (led_flip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q     <= '0;
      step_in    <= 1'b0;
      step_out   <= 1'b0;
      led_strobe <= 1'b0;
    end else begin
      step_in    <= wr_en & hit_in;
      step_out   <= wr_en & hit_out;
      led_strobe <= led_flip;
      if (wr_en) port_q <= wr_data & KEEP_MASK;
    end
  end

  assign led_level = port_q[LED_BIT];
endmodule

// File: rtl/stepper_port_ctl_chk.sv
module stepper_port_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] port_q,
  input logic       step_in,
  input logic       step_out,
  input logic       led_level,
  input logic       led_strobe
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (port_q == 8'h00 && !step_in && !step_out && !led_strobe));

  a_r2_store_masked: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (port_q == ($past(wr_data) & 8'hEF)));

  a_r3_step_out: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_q[1:0] == wr_data[1:0] + 2'd1) |=> (step_out && !step_in));

  a_r4_step_in: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_q[1:0] == wr_data[1:0] - 2'd1) |=> (step_in && !step_out));

  a_r5_no_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (port_q[1:0] == wr_data[1:0] || port_q[1:0] == wr_data[1:0] + 2'd2))
      |=> (!step_in && !step_out));

  a_r6_led_bit4_low: assert property (@(posedge clk) disable iff (rst)
    (led_level == port_q[3]) && !port_q[4]);

  a_r7_led_toggle: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[3] != port_q[3]) |=> (led_strobe && led_level == $past(wr_data[3])));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (!step_in && !step_out && !led_strobe && $stable(port_q)));
endmodule

bind stepper_port_ctl stepper_port_ctl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .port_q(port_q),
  .step_in(step_in), .step_out(step_out), .led_level(led_level), .led_strobe(led_strobe)
);

// File: tb/test_stepper_port_ctl.sv
module test_stepper_port_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] port_q;
  logic       step_in, step_out, led_level, led_strobe;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  stepper_port_ctl i_stepper_port_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .port_q(port_q),
    .step_in(step_in), .step_out(step_out), .led_level(led_level), .led_strobe(led_strobe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Write v; check stored value, pulses, LED; then one idle cycle.
  task automatic write_check(input logic [7:0] v);
    logic [7:0] held;
    logic [1:0] hp, np;
    logic eo, ei, es;
    held = port_q;
    hp = held[1:0];
    np = v[1:0];
    eo = (hp == 2'((np + 1) % 4));
    ei = (hp == 2'((np + 3) % 4));
    es = held[3] ^ v[3];
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(posedge clk); #1;
    check("R2 store", port_q, v & 8'hEF);
    if (eo)      check("R3 step_out", {6'd0, step_out, step_in}, 8'h02);
    else if (ei) check("R4 step_in", {6'd0, step_out, step_in}, 8'h01);
    else         check("R5 no step", {6'd0, step_out, step_in}, 8'h00);
    check("R6 led level", {7'd0, led_level}, {7'd0, v[3]});
    check("R7 led strobe", {7'd0, led_strobe}, {7'd0, es});
    @(negedge clk);
    wr_en = 1'b0; wr_data = ~v;
    @(posedge clk); #1;
    check("R8 pulses end", {5'd0, step_out, step_in, led_strobe}, 8'h00);
    check("R8 hold", port_q, v & 8'hEF);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset port", port_q, 8'h00);
    check("R1 reset pulses", {5'd0, step_out, step_in, led_strobe}, 8'h00);
    check("R1 reset led", {7'd0, led_level}, 8'h00);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 after reset", port_q, 8'h00);
    // Sweep: every held phase and LED state against all written bytes.
    for (int h = 0; h < 8; h++) begin
      for (int n = 0; n < 256; n++) begin
        write_check(8'((h[1:0]) | (h[2] << 3) | 8'hF4));
        write_check(8'(n));
      end
    end
    // Walk the phase forward and backward in sequence.
    for (int k = 0; k < 8; k++) write_check(8'(k % 4));
    for (int k = 8; k > 0; k--) write_check(8'(k % 4));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule